// File: doc/BRIEF.md
# Bit-Plane Lookup Dot-Product Engine

This block forms the dot product of K signed 8-bit activations with K unsigned low-bit weights and uses no multiplier. The activations are loaded once per vector. The engine then works through them in groups of G. For each group it builds a small table that holds the sum of every subset of the group's activations. The weights arrive one bit plane at a time as packed G-bit patterns. Each pattern is an index into the current table. The value read out is shifted left by its plane number and added to a signed accumulator.

Every plane reads the same per-group table, so table storage does not grow with the weight width. Three things happen in turn: a producer streams in the activations, a second producer streams in the weight beats, and the consumer takes the finished sum when the one-cycle done strobe fires. The accumulator clears when the next vector begins.

Top module: `lut_dot_engine`

## Requirements
- R1: While reset is held and just after it is released, `act_ready` is 1, `wb_ready` is 0 and `res_done` is 0.
- R2: `act_ready` stays high until exactly K activation beats (`act_valid` and `act_ready` both 1) have been taken. It then stays low until the result strobe has fired. `act_ready` and `wb_ready` are never high together.
- R3: `res_sum` equals the sum of a[k]·w[k] for k from 0 to K-1. Weight beats arrive group by group (group j covers activations j·G to j·G+G-1). Within a group they arrive plane by plane, from plane 0 to plane WBITS-1. Bit t of a beat is bit i of w[j·G+t], and plane i carries weight 2^i.
- R4: For each group, the table has 2^G entries. Entry p holds the sum of the activations whose position bit is set in p, and entry 0 is zero. Entries are built one per cycle. After the last activation beat, and after the last beat of each group that is not the final group, `wb_ready` is low for exactly 2^G-1 cycles (15 for G=4).
- R5: A weight beat offered while `wb_ready` is low is ignored and leaves the result unchanged.
- R6: `res_done` is high for exactly one cycle, in the cycle after the final weight beat is taken, and `res_sum` holds the final sum in that cycle.
- R7: The accumulator clears when the first activation of a new vector is taken, so each result depends only on its own vector.
- R8: An activation beat offered while `act_ready` is low is ignored.
- R9: The accumulator never overflows, even at the extremes. With all activations at -128 and all weights at 15 the result is -61440. With all activations at 127 and all weights at 15 it is 60960.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Activation beat offered |
| act_ready | output | 1 | Engine accepts an activation beat |
| act_data | input | AW | Signed activation, taken in index order 0..K-1 |
| wb_valid | input | 1 | Weight-pattern beat offered |
| wb_ready | output | 1 | Engine accepts a weight-pattern beat |
| wb_bits | input | G | One plane of G packed weight bits for the current group |
| res_done | output | 1 | One-cycle strobe marking the final sum |
| res_sum | output | ACCW | Signed accumulated dot product |

## Verification
The hardest state to reach from the ports is a beat offered while the engine is not ready. Such a beat would corrupt the sum only if it slipped into a table build or into the accumulator. To cover this, the bench keeps `wb_valid` high with an all-ones pattern for the whole activation load and into the first table build. It also keeps `act_valid` high with junk data throughout the lookup phase and the gaps between groups. Every such vector must still produce the exact reference sum. Extreme vectors, with activations saturated at both signs and full-scale weights, drive the accumulator to its bounds.

// File: rtl/lut_dot_pkg.sv
package lut_dot_pkg;

    typedef enum logic [1:0] {
        S_LOAD  = 2'd0,
        S_BUILD = 2'd1,
        S_LOOK  = 2'd2,
        S_DONE  = 2'd3
    } eng_state_t;

    // position of the lowest set bit; 0 when none is set
    function automatic int unsigned low_bit(input logic [7:0] v);
        int unsigned r;
        r = 0;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/lut_act_store.sv
module lut_act_store #(
    parameter int K  = 32,
    parameter int G  = 4,
    parameter int AW = 8,
    localparam int KIW = $clog2(K),
    localparam int NG  = K / G,
    localparam int GIW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [KIW-1:0]               wr_idx,
    input  logic signed [AW-1:0]         wr_data,
    input  logic [GIW-1:0]               rd_grp,
    output logic [G-1:0][AW-1:0]         grp_acts
);
    logic [AW-1:0] mem [K];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    for (genvar t = 0; t < G; t++) begin : g_rd
        always_comb grp_acts[t] = mem[KIW'(int'(rd_grp) * G + t)];
    end
endmodule

// File: rtl/lut_subset_table.sv
module lut_subset_table
    import lut_dot_pkg::*;
#(
    parameter int G  = 4,
    parameter int AW = 8,
    parameter int EW = 11,
    localparam int NENT = 2 ** G,
    localparam int LBW  = (G > 1) ? $clog2(G) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bld_en,
    input  logic [G-1:0]             bld_idx,
    input  logic [G-1:0][AW-1:0]     grp_acts,
    input  logic [G-1:0]             rd_pat,
    output logic signed [EW-1:0]     rd_val
);
    logic signed [EW-1:0] ent [NENT];
    logic [G-1:0]         parent;
    logic [LBW-1:0]       lb;
    logic signed [AW-1:0] pick;
    logic signed [EW-1:0] new_val;

    always_comb begin
        parent  = bld_idx & (bld_idx - 1'b1);
        lb      = LBW'(low_bit(8'(bld_idx)));
        pick    = signed'(grp_acts[lb]);
        new_val = ent[parent] + EW'(pick);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) ent[i] <= '0;
        end else if (bld_en && bld_idx != '0) begin
            ent[bld_idx] <= new_val;
        end
    end

    assign rd_val = ent[rd_pat];

    // R4
    empty_entry_chk: assert property (@(posedge clk) disable iff (rst)
        bld_en |=> ent[0] == '0);
endmodule

// File: rtl/lut_plane_acc.sv
module lut_plane_acc #(
    parameter int EW    = 11,
    parameter int ACCW  = 19,
    parameter int PW    = 2,
    parameter int AW    = 8,
    parameter int WBITS = 4,
    parameter int K     = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      add_en,
    input  logic [PW-1:0]             plane,
    input  logic signed [EW-1:0]      val,
    output logic signed [ACCW-1:0]    acc
);
    localparam longint LIM = (64'sd1 <<< (AW - 1)) * ((64'sd1 <<< WBITS) - 1) * K;

    logic signed [ACCW-1:0] addend;

    always_comb addend = ACCW'(val) <<< plane;

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (add_en) acc <= acc + addend;
    end

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> acc == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (longint'(acc) <= LIM) && (longint'(acc) >= -LIM));
endmodule

// File: rtl/lut_dot_engine.sv
module lut_dot_engine
    import lut_dot_pkg::*;
#(
    parameter int G     = 4,
    parameter int WBITS = 4,
    parameter int AW    = 8,
    parameter int K     = 32,
    localparam int NG   = K / G,
    localparam int NENT = 2 ** G,
    localparam int EW   = AW + $clog2(G) + 1,
    localparam int ACCW = EW + WBITS + $clog2(NG) + 1,
    localparam int KIW  = $clog2(K),
    localparam int GIW  = (NG > 1) ? $clog2(NG) : 1,
    localparam int PW   = (WBITS > 1) ? $clog2(WBITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   act_valid,
    output logic                   act_ready,
    input  logic [AW-1:0]          act_data,
    input  logic                   wb_valid,
    output logic                   wb_ready,
    input  logic [G-1:0]           wb_bits,
    output logic                   res_done,
    output logic [ACCW-1:0]        res_sum
);
    eng_state_t           state;
    logic [KIW-1:0]       act_cnt;
    logic [GIW-1:0]       grp;
    logic [G-1:0]         bidx;
    logic [PW-1:0]        plane;
    logic                 act_fire, wb_fire;
    logic [G-1:0][AW-1:0] grp_acts;
    logic signed [EW-1:0] tbl_val;
    logic signed [ACCW-1:0] acc;

    assign act_ready = (state == S_LOAD);
    assign wb_ready  = (state == S_LOOK);
    assign res_done  = (state == S_DONE);
    assign act_fire  = act_valid && act_ready;
    assign wb_fire   = wb_valid && wb_ready;
    assign res_sum   = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_LOAD;
            act_cnt <= '0;
            grp     <= '0;
            bidx    <= '0;
            plane   <= '0;
        end else begin
            case (state)
                S_LOAD: if (act_fire) begin
                    if (act_cnt == KIW'(K - 1)) begin
                        act_cnt <= '0;
                        grp     <= '0;
                        bidx    <= G'(1);
                        state   <= S_BUILD;
                    end else begin
                        act_cnt <= act_cnt + 1'b1;
                    end
                end
                S_BUILD: begin
                    if (bidx == G'(NENT - 1)) begin
                        plane <= '0;
                        state <= S_LOOK;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
                S_LOOK: if (wb_fire) begin
                    if (plane == PW'(WBITS - 1)) begin
                        if (grp == GIW'(NG - 1)) begin
                            state <= S_DONE;
                        end else begin
                            grp   <= grp + 1'b1;
                            bidx  <= G'(1);
                            state <= S_BUILD;
                        end
                    end else begin
                        plane <= plane + 1'b1;
                    end
                end
                default: state <= S_LOAD;
            endcase
        end
    end

    lut_act_store #(.K(K), .G(G), .AW(AW)) store_i (
        .clk      (clk),
        .wr_en    (act_fire),
        .wr_idx   (act_cnt),
        .wr_data  (act_data),
        .rd_grp   (grp),
        .grp_acts (grp_acts)
    );

    lut_subset_table #(.G(G), .AW(AW), .EW(EW)) table_i (
        .clk      (clk),
        .rst      (rst),
        .bld_en   (state == S_BUILD),
        .bld_idx  (bidx),
        .grp_acts (grp_acts),
        .rd_pat   (wb_bits),
        .rd_val   (tbl_val)
    );

    lut_plane_acc #(.EW(EW), .ACCW(ACCW), .PW(PW), .AW(AW), .WBITS(WBITS), .K(K)) acc_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (act_fire && act_cnt == '0),
        .add_en (wb_fire),
        .plane  (plane),
        .val    (tbl_val),
        .acc    (acc)
    );

    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(act_ready && wb_ready));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);

    // R5
    wb_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_BUILD) |=> $stable(acc));

    // R4
    build_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_BUILD && bidx != G'(NENT - 1)) |=> state == S_BUILD);

    // R8
    act_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOOK) |=> $stable(act_cnt));
endmodule

// File: tb/lut_dot_engine_tb_top.sv
module lut_dot_engine_tb_top;
    localparam int G    = 4;
    localparam int WB   = 4;
    localparam int AW   = 8;
    localparam int K    = 32;
    localparam int NG   = K / G;
    localparam int EW   = AW + $clog2(G) + 1;
    localparam int ACCW = EW + WB + $clog2(NG) + 1;

    // amode, aval, wmode, wval, seed, junk, lit_valid, lit  (mode 1 = constant)
    localparam int NC = 8;
    localparam int TAB [NC][8] = '{
        '{1, -128, 1, 15,  0, 0, 1, -61440},
        '{1,  127, 1, 15,  0, 1, 1,  60960},
        '{1,  127, 1,  0,  0, 0, 1,      0},
        '{1,   -1, 1,  1,  0, 1, 1,    -32},
        '{0,    0, 0,  0,  1, 1, 0,      0},
        '{0,    0, 0,  0, 77, 0, 0,      0},
        '{0,    0, 1,  8,  5, 1, 0,      0},
        '{1, -128, 0,  0,  9, 0, 0,      0}
    };

    logic clk = 1'b0;
    logic rst;
    logic act_valid, act_ready, wb_valid, wb_ready, res_done;
    logic [AW-1:0] act_data;
    logic [G-1:0] wb_bits;
    logic [ACCW-1:0] res_sum;

    int n_run = 0;
    int n_fail = 0;
    int unsigned lcg;
    logic signed [AW-1:0] av [K];
    logic [WB-1:0] wv [K];

    always #10 clk = ~clk;

    lut_dot_engine #(.G(G), .WBITS(WB), .AW(AW), .K(K)) dut_i (
        .clk(clk), .rst(rst),
        .act_valid(act_valid), .act_ready(act_ready), .act_data(act_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_bits(wb_bits),
        .res_done(res_done), .res_sum(res_sum)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    function automatic logic [7:0] rnd();
        lcg = lcg * 1103515245 + 12345;
        return lcg[23:16];
    endfunction

    function automatic longint ref_dot();
        longint s = 0;
        for (int k = 0; k < K; k++) s += longint'(av[k]) * longint'(wv[k]);
        return s;
    endfunction

    // R2, R4, R5: load K activations, optionally with junk weight beats offered
    task automatic load_vec(input bit junk);
        int low;
        for (int k = 0; k < K; k++) begin
            @(negedge clk);
            act_valid = 1'b1;
            act_data  = av[k];
            wb_valid  = junk;
            wb_bits   = '1;
        end
        @(negedge clk);
        act_valid = 1'b0;
        chk(act_ready == 1'b0, "R2 act_ready after K beats", act_ready, 0);
        low = 0;
        while (!wb_ready && low < 100) begin
            low++;
            if (low == 3) wb_valid = 1'b0;
            @(negedge clk);
        end
        wb_valid = 1'b0;
        chk(low == 15, "R4 build gap", low, 15);
    endtask

    // R3, R6, R8: stream weight planes, optionally with junk activation beats offered
    task automatic send_w(input bit junk, input longint exp);
        for (int j = 0; j < NG; j++) begin
            for (int i = 0; i < WB; i++) begin
                while (!wb_ready) @(negedge clk);
                wb_valid = 1'b1;
                for (int t = 0; t < G; t++) wb_bits[t] = wv[j*G+t][i];
                act_valid = junk;
                act_data  = 8'h55;
                @(negedge clk);
                wb_valid = 1'b0;
            end
        end
        act_valid = 1'b0;
        chk(res_done == 1'b1, "R6 done after last beat", res_done, 1);
        chk(longint'(signed'(res_sum)) == exp, "R3 R9 sum", longint'(signed'(res_sum)), exp);
        @(negedge clk);
        chk(res_done == 1'b0, "R6 done one cycle", res_done, 0);
        chk(act_ready == 1'b1, "R2 ready for next vector", act_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        longint exp;
        rst = 1'b1; act_valid = 1'b0; wb_valid = 1'b0; act_data = '0; wb_bits = '0;
        repeat (3) @(negedge clk);
        // R1
        chk(act_ready == 1'b1, "R1 act_ready", act_ready, 1);
        chk(wb_ready == 1'b0, "R1 wb_ready", wb_ready, 0);
        chk(res_done == 1'b0, "R1 res_done", res_done, 0);
        rst = 1'b0;

        // table-driven vectors, back to back (R7 holds across them)
        for (int c = 0; c < NC; c++) begin
            lcg = TAB[c][4];
            for (int k = 0; k < K; k++) begin
                av[k] = (TAB[c][0] == 1) ? AW'(TAB[c][1]) : rnd();
                wv[k] = (TAB[c][2] == 1) ? WB'(TAB[c][3]) : WB'(rnd());
            end
            exp = (TAB[c][6] == 1) ? longint'(TAB[c][7]) : ref_dot();
            if (TAB[c][6] == 1) chk(ref_dot() == exp, "R9 reference", ref_dot(), exp);
            load_vec(TAB[c][5] != 0);
            send_w(TAB[c][5] != 0, exp);
        end

        // R7: after a large result, zero weights must give zero
        for (int k = 0; k < K; k++) begin av[k] = 8'sd100; wv[k] = '0; end
        load_vec(1'b0);
        send_w(1'b0, 0);

        // R3: single nonzero weight at the last position, top plane only
        for (int k = 0; k < K; k++) begin av[k] = 8'sd3; wv[k] = '0; end
        av[K-1] = -8'sd7; wv[K-1] = 4'd8;
        load_vec(1'b1);
        send_w(1'b1, -56);

        // R1: reset in the middle of a vector returns to load state
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); act_valid = 1'b1; act_data = 8'h11;
        end
        @(negedge clk); act_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(act_ready == 1'b1 && wb_ready == 1'b0 && res_done == 1'b0,
            "R1 mid reset", {act_ready, wb_ready, res_done}, 3'b100);
        rst = 1'b0;

        // R7: fresh vector after reset is independent of the partial load
        for (int k = 0; k < K; k++) begin av[k] = AW'(k - 16); wv[k] = WB'(k % 16); end
        exp = ref_dot();
        load_vec(1'b0);
        send_w(1'b0, exp);

        summary();
    end
endmodule